// File: doc/BRIEF.md
# Manchester Frame Transmit Sequencer

This block sends one fieldbus frame on a single serial line. A frame has four parts that always follow each other in the same order. First comes a fixed start pattern. Next come the payload bytes, each one Manchester expanded. Then comes a 16-bit CRC, also Manchester expanded. Last comes a fixed end pattern. A short stop interval, with the line held low, closes the frame.

Each half-bit goes out on the edge that samples the periodic half-bit tick input. The tick is made elsewhere from the system clock. Payload bytes are pulled from an upstream source one at a time over a ready/valid handshake. The byte count is latched when the frame starts. The CRC is built serially from the plain payload bits. It goes on the line inverted.

A registered transmit enable opens only after the first tick of the frame and closes after the stop interval. A one-cycle done pulse tells the upstream logic that the line is free again. The start and end patterns are parameters.

Top module: `manch_frame_tx`

## Requirements
- R1: After a synchronous active-high reset, `txd_o`, `tx_en_o`, `done_o` and `byte_ready_o` are all 0.
- R2: The first 16 half-bits of a frame are the bits of `SOF_PAT`, sent from bit 15 down to bit 0.
- R3: A payload bit of value 1 is sent as half-bits 1 then 0. A bit of value 0 is sent as 0 then 1. Bits go out from bit 7 to bit 0, and bytes go out in the order they were accepted, so each byte takes 16 half-bits.
- R4: A byte is accepted on each clock edge where `byte_ready_o` and `byte_valid_i` are both high. Exactly `byte_count_i` bytes are accepted per frame. A count of 0 skips the payload part.
- R5: The CRC register is preset to 0xFFFF when a frame starts. For each payload bit d, taken from bit 7 down to bit 0, it steps as follows: fb = q[15]^d, then q = (q<<1) ^ (fb ? 0x1DCF : 0). The complement of q is then sent from bit 15 down to bit 0, Manchester coded, as 32 half-bits.
- R6: After the CRC come the 16 bits of `EOF_PAT`, from bit 15 down to bit 0. The next tick then drives the line low and ends the frame.
- R7: `txd_o` changes only on an edge where `bit_tick_i` is sampled high, and it is 0 whenever no frame is in progress.
- R8: `tx_en_o` is still 0 right after the edge that takes the first tick of a frame. It is 1 from the following edge until one cycle after `done_o`.
- R9: `done_o` is a single-cycle pulse. It is produced on the edge that takes the stop-interval tick, and at no other time.
- R10: A `start_i` pulse during a frame is ignored: the frame in progress and its CRC are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that starts a frame when idle |
| byte_count_i | input | CNT_W | Number of payload bytes, latched at start |
| bit_tick_i | input | 1 | One-cycle half-bit tick |
| byte_valid_i | input | 1 | Upstream byte is valid |
| byte_data_i | input | 8 | Upstream byte |
| byte_ready_o | output | 1 | Block is ready to take a byte |
| txd_o | output | 1 | Serial line |
| tx_en_o | output | 1 | Transmit enable |
| done_o | output | 1 | Frame finished pulse |

## Verification
The bench builds the block with start and end patterns other than the defaults: 0xC3A5 and 0x5F0A. These patterns hold runs and alternations in both halves, so a wrong bit order or a missed pattern bit shows on the line. `CNT_W` stays at 8 with counts up to 8. This covers the empty payload, a single byte of all zeros or all ones, and several random multi-byte payloads. Tick spacing is drawn from three to six clocks, so the byte fetch between ticks and the enable delay are checked at their tightest spacing.

// File: rtl/manch_frame_tx.sv
module manch_frame_tx #(
  parameter int          CNT_W    = 8,
  parameter logic [15:0] SOF_PAT  = 16'hA8D5,
  parameter logic [15:0] EOF_PAT  = 16'hD4FD,
  parameter logic [15:0] CRC_POLY = 16'h1DCF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             bit_tick_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  output logic             txd_o,
  output logic             tx_en_o,
  output logic             done_o
);

  typedef enum logic [2:0] {ST_IDLE, ST_SOF, ST_DATA, ST_CRC, ST_EOF, ST_STOP} st_t;

  st_t              st;
  logic [4:0]       idx;
  logic [CNT_W-1:0] left;
  logic             have;
  logic [7:0]       cur;
  logic [15:0]      crc_q;
  logic             armed;

  wire        busy     = (st != ST_IDLE);
  wire [15:0] crc_out  = ~crc_q;
  wire        data_bit = cur[idx[3:1]];
  wire        crc_bit  = crc_out[idx[4:1]];
  wire        last     = (idx == 5'd0);

  assign byte_ready_o = (st == ST_DATA) && !have && (left != '0);

  function automatic logic [15:0] crc_step(input logic [15:0] q, input logic d);
    logic fb;
    fb = q[15] ^ d;
    return {q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx     <= '0;
      left    <= '0;
      have    <= 1'b0;
      cur     <= '0;
      crc_q   <= 16'hFFFF;
      txd_o   <= 1'b0;
      armed   <= 1'b0;
      tx_en_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      armed   <= busy && (armed || bit_tick_i);
      tx_en_o <= busy && armed;
      if (byte_ready_o && byte_valid_i) begin
        cur  <= byte_data_i;
        have <= 1'b1;
        left <= left - 1'b1;
      end
      case (st)
        ST_IDLE: if (start_i) begin
          st    <= ST_SOF;
          idx   <= 5'd15;
          left  <= byte_count_i;
          crc_q <= 16'hFFFF;
        end
        ST_SOF: if (bit_tick_i) begin
          txd_o <= SOF_PAT[idx[3:0]];
          if (last) begin
            st  <= (left == '0) ? ST_CRC : ST_DATA;
            idx <= (left == '0) ? 5'd31 : 5'd15;
          end else idx <= idx - 1'b1;
        end
        ST_DATA: if (bit_tick_i && have) begin
          txd_o <= idx[0] ? data_bit : ~data_bit;
          if (idx[0]) crc_q <= crc_step(crc_q, data_bit);
          if (last) begin
            have <= 1'b0;
            st   <= (left == '0) ? ST_CRC : ST_DATA;
            idx  <= (left == '0) ? 5'd31 : 5'd15;
          end else idx <= idx - 1'b1;
        end
        ST_CRC: if (bit_tick_i) begin
          txd_o <= idx[0] ? crc_bit : ~crc_bit;
          if (last) begin
            st  <= ST_EOF;
            idx <= 5'd15;
          end else idx <= idx - 1'b1;
        end
        ST_EOF: if (bit_tick_i) begin
          txd_o <= EOF_PAT[idx[3:0]];
          if (last) st <= ST_STOP;
          else idx <= idx - 1'b1;
        end
        ST_STOP: if (bit_tick_i) begin
          txd_o  <= 1'b0;
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_line_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !txd_o);
  assert_line_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd_o) |-> $past(bit_tick_i));
  assert_enable_closes_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !tx_en_o);
  assert_enable_opens_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en_o) |-> busy);
  assert_single_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_ready_o && byte_valid_i) |=> !byte_ready_o);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: tb/manch_frame_tx_tb_top.sv
`timescale 1ns/1ps
module manch_frame_tx_tb_top;
  localparam logic [15:0] SOF = 16'hC3A5;
  localparam logic [15:0] EOF = 16'h5F0A;
  localparam logic [15:0] POLY = 16'h1DCF;

  logic clk = 0, rst = 1, start = 0, tick = 0, valid = 1, kclr = 0;
  logic [7:0] cnt = 0;
  logic [7:0] arr [0:15];
  int k;
  logic ready, txd, txen, done;
  logic [7:0] bdata;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic exp_bits [0:511];

  always #2 clk = ~clk;
  assign bdata = arr[k[3:0]];

  always @(posedge clk)
    if (kclr) k <= 0;
    else if (ready && valid) k <= k + 1;

  manch_frame_tx #(.CNT_W(8), .SOF_PAT(SOF), .EOF_PAT(EOF)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .byte_count_i(cnt),
    .bit_tick_i(tick), .byte_valid_i(valid), .byte_data_i(bdata),
    .byte_ready_o(ready), .txd_o(txd), .tx_en_o(txen), .done_o(done));

  task automatic chk(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp_v, $time);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] q = 16'hFFFF;
    logic fb;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = q[15] ^ arr[i][b];
        q = {q[14:0], 1'b0} ^ (fb ? POLY : 16'h0);
      end
    return ~q;
  endfunction

  task automatic tick_once(input int gap);
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic run_frame(input int n, input bit poke);
    int total, p, gap;
    logic [15:0] c;
    string req;
    total = 64 + 16 * n;
    p = 0;
    for (int b = 15; b >= 0; b--) exp_bits[p++] = SOF[b];
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin exp_bits[p++] = arr[i][b]; exp_bits[p++] = ~arr[i][b]; end
    c = crc_of(n);
    for (int b = 15; b >= 0; b--) begin exp_bits[p++] = c[b]; exp_bits[p++] = ~c[b]; end
    for (int b = 15; b >= 0; b--) exp_bits[p++] = EOF[b];
    @(negedge clk) begin kclr = 1; cnt = 8'(n); end
    @(negedge clk) begin kclr = 0; start = 1; end
    @(negedge clk) start = 0;
    chk("R8 enable before first tick", txen, 1'b0);
    for (int h = 0; h < total; h++) begin
      gap = 3 + int'($urandom_range(0, 3));
      if (poke && h == 20) begin
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
      end
      tick_once(gap);
      if (h < 16) req = "R2 start pattern";
      else if (h < 16 + 16 * n) req = "R3 payload";
      else if (h < 48 + 16 * n) req = "R5 crc";
      else req = "R6 end pattern";
      if (poke) req = {req, " R10"};
      chk(req, txd, exp_bits[h]);
      chk("R9 no early done", done, 1'b0);
      if (h == 0) chk("R8 enable still low at first tick", txen, 1'b0);
      else chk("R8 enable high in frame", txen, 1'b1);
      repeat (gap - 2) @(negedge clk);
    end
    tick_once(3);
    chk("R6 stop interval low", txd, 1'b0);
    chk("R9 done pulse", done, 1'b1);
    chk("R8 enable held at done", txen, 1'b1);
    @(negedge clk);
    chk("R9 done single cycle", done, 1'b0);
    chk("R8 enable dropped", txen, 1'b0);
    chk("R7 line low after frame", txd, 1'b0);
    checks++;
    if (k != n) begin
      fails++;
      $display("FAIL R4 bytes accepted actual=%0d expected=%0d", k, n);
    end
    chk("R4 no ready when idle", ready, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) arr[i] = 8'h00;
    k = 0;
    repeat (3) @(negedge clk);
    chk("R1 txd reset", txd, 1'b0);
    chk("R1 tx_en reset", txen, 1'b0);
    chk("R1 done reset", done, 1'b0);
    chk("R1 ready reset", ready, 1'b0);
    @(negedge clk) rst = 0;
    run_frame(0, 0);
    arr[0] = 8'h00; run_frame(1, 0);
    arr[0] = 8'hFF; run_frame(1, 0);
    for (int f = 0; f < 6; f++) begin
      int n;
      n = int'($urandom_range(2, 8));
      for (int i = 0; i < n; i++) arr[i] = 8'($urandom);
      run_frame(n, f == 2);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule